// File: doc/BRIEF.md
# Multi-hart timer and software-interrupt unit

This unit sits beside a cluster of processor harts. Each hart gets a software interrupt pending bit and a 64-bit compare register. All harts share one 64-bit time counter. The unit drives one machine software interrupt line and one machine timer interrupt line per hart. A hart's timer line is high while its compare value is at or below the current time. Software raises a software interrupt on another hart by writing bit 0 of that hart's word.

Access is through a 32-bit register bus. A requester holds `bus_req` with an address, a write flag and write data. The bus sequencer has two states:
- `BUS_IDLE`: a request is accepted, and the write is applied or the read data is latched. The transition is `BUS_IDLE -> BUS_RESP` when `bus_req` is high; otherwise the sequencer stays in `BUS_IDLE`.
- `BUS_RESP`: `bus_ready` is high for one cycle. The transition `BUS_RESP -> BUS_IDLE` is taken unconditionally.

The requester drops `bus_req` in the cycle it sees `bus_ready`.

Three regions can each be moved by a parameter:
- the software-interrupt words, one per hart;
- the compare registers, one per hart;
- the time counter.

The time counter advances on an external tick enable, which comes from a prescaler outside the block.

Top module: `hart_timer_ipi`

## Requirements
- R1: A request seen in `BUS_IDLE` is accepted on that clock edge, and its write takes effect on that edge. `bus_ready` is then high for exactly one cycle, and for a read `bus_rdata` holds the word read.
- R2: The software-interrupt region holds one word per hart at a 4-byte stride from `SWI_BASE`. A write sets that hart's `msip_o` bit to write-data bit 0. A read returns the pending bit in bit 0, with the other bits zero.
- R3: The compare region holds one 64-bit register per hart at an 8-byte stride from `CMP_BASE`. Bits 31:0 are at offset 0 and bits 63:32 are at offset 4. Both halves read back what was written.
- R4: Writing one half of a compare register leaves the other half unchanged.
- R5: `mtip_o[i]` is the unsigned 64-bit comparison compare(i) <= time. It is evaluated every cycle and shows up one cycle after time or the compare value changes, so a compare value in the future drops the line.
- R6: The time counter advances by one on every clock with `tick_en` high, holds otherwise, and wraps modulo 2^64.
- R7: The low word of time reads at `TIME_BASE` and the high word at `TIME_BASE`+4. Writes to either word do not change the counter.
- R8: The following accesses read as 0 and have no effect when written: an address with bits 1:0 not zero, a hart index at or above `NUM_HARTS`, or an address outside all three regions.
- R9: Reset clears every compare register and every pending bit, and loads the time counter with `TIME_RESET`.
- R10: Reading time as high, low, high, and repeating while the two high words differ, gives the value the counter held when the low word was read, even across a low-word rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick; the time counter steps when high |
| bus_req | input | 1 | Request valid, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | One-cycle completion strobe |
| msip_o | output | NUM_HARTS | Machine software interrupt per hart |
| mtip_o | output | NUM_HARTS | Machine timer interrupt per hart |

## Verification
Two functions can land on the same clock edge:
- a compare-register write;
- the time counter stepping past the value being written.

The bench provokes this by writing a compare value a few ticks ahead while `tick_en` runs. It does the same when it writes the high half of a compare register while the live counter is close to the new value. A behavioural model steps the counter, applies the write and registers each timer line on the same edges. The timer lines are compared on every clock, so a line that rises one cycle early or late is reported. The high-low-high rollover read is judged in the same way, against the model's counter value on the edge where the low word was accepted.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned TIME_W = 64;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_SWI  = 2'd1,
        RGN_CMP  = 2'd2,
        RGN_TIME = 2'd3
    } region_e;
endpackage

// File: rtl/hart_timer_bus_fsm.sv
module hart_timer_bus_fsm
    import hart_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept_o,
    output logic ready_o
);
    bus_state_e state_q, state_d;

    // R1: accept in idle, respond exactly one cycle later
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept_o = (state_q == BUS_IDLE) && req;
        ready_o  = (state_q == BUS_RESP);
    end
endmodule

// File: rtl/hart_timer_tick.sv
module hart_timer_tick
    import hart_timer_pkg::*;
#(
    parameter logic [TIME_W-1:0] TIME_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [TIME_W-1:0] now_o
);
    // R6: single step per tick, natural wrap; R9: reset load
    always_ff @(posedge clk) begin
        if (!rst_n)       now_o <= TIME_RESET;
        else if (tick_en) now_o <= now_o + TIME_W'(1);
    end
endmodule

// File: rtl/hart_timer_slot.sv
module hart_timer_slot
    import hart_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swi_wr,
    input  logic              cmp_wr_lo,
    input  logic              cmp_wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic [TIME_W-1:0] now_i,
    output logic              msip_o,
    output logic              mtip_o,
    output logic [TIME_W-1:0] cmp_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msip_o <= 1'b0;
            mtip_o <= 1'b0;
            cmp_o  <= '0;                              // R9
        end else begin
            if (swi_wr)    msip_o <= wdata[0];         // R2
            if (cmp_wr_lo) cmp_o[WORD_W-1:0] <= wdata; // R4: half only
            if (cmp_wr_hi) cmp_o[TIME_W-1:WORD_W] <= wdata;
            mtip_o <= (cmp_o <= now_i);                // R5: unsigned, registered
        end
    end
endmodule

// File: rtl/hart_timer_ipi.sv
module hart_timer_ipi
    import hart_timer_pkg::*;
#(
    parameter int unsigned         NUM_HARTS  = 2,
    parameter int unsigned         ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]   SWI_BASE   = 'h0000,
    parameter logic [ADDR_W-1:0]   CMP_BASE   = 'h4000,
    parameter logic [ADDR_W-1:0]   TIME_BASE  = 'hBFF8,
    parameter logic [TIME_W-1:0]   TIME_RESET = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 bus_ready,
    output logic [NUM_HARTS-1:0] msip_o,
    output logic [NUM_HARTS-1:0] mtip_o
);
    localparam int unsigned IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
    localparam logic [31:0] SWI_SPAN = 32'(NUM_HARTS) * 32'd4;
    localparam logic [31:0] CMP_SPAN = 32'(NUM_HARTS) * 32'd8;

    logic                                accept;
    logic [TIME_W-1:0]                   now_w;
    logic [NUM_HARTS-1:0][TIME_W-1:0]    cmp_w;

    region_e           rgn;
    logic [IDX_W-1:0]  idx;
    logic              hi_word;
    logic [31:0]       addr32, swi_off, cmp_off;
    logic [WORD_W-1:0] rd_word;

    hart_timer_bus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .accept_o (accept),
        .ready_o  (bus_ready)
    );

    hart_timer_tick #(.TIME_RESET(TIME_RESET)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .now_o   (now_w)
    );

    // Address decode (R2, R3, R7, R8): aligned words only, in-range harts only
    always_comb begin
        addr32  = 32'(bus_addr);
        swi_off = addr32 - 32'(SWI_BASE);
        cmp_off = addr32 - 32'(CMP_BASE);
        rgn     = RGN_NONE;
        idx     = '0;
        hi_word = 1'b0;
        if (addr32[1:0] == 2'b00) begin
            if (addr32 >= 32'(SWI_BASE) && swi_off < SWI_SPAN) begin
                rgn = RGN_SWI;
                idx = swi_off[IDX_W+1:2];
            end else if (addr32 >= 32'(CMP_BASE) && cmp_off < CMP_SPAN) begin
                rgn     = RGN_CMP;
                idx     = cmp_off[IDX_W+2:3];
                hi_word = cmp_off[2];
            end else if (addr32 == 32'(TIME_BASE)) begin
                rgn = RGN_TIME;
            end else if (addr32 == 32'(TIME_BASE) + 32'd4) begin
                rgn     = RGN_TIME;
                hi_word = 1'b1;
            end
        end
    end

    generate
        for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
            logic sel;
            assign sel = accept && bus_we && (idx == IDX_W'(h));
            hart_timer_slot u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .swi_wr    (sel && rgn == RGN_SWI),
                .cmp_wr_lo (sel && rgn == RGN_CMP && !hi_word),
                .cmp_wr_hi (sel && rgn == RGN_CMP && hi_word),
                .wdata     (bus_wdata),
                .now_i     (now_w),
                .msip_o    (msip_o[h]),
                .mtip_o    (mtip_o[h]),
                .cmp_o     (cmp_w[h])
            );
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        unique case (rgn)
            RGN_SWI:  rd_word = {{(WORD_W-1){1'b0}}, msip_o[idx]};
            RGN_CMP:  rd_word = hi_word ? cmp_w[idx][TIME_W-1:WORD_W] : cmp_w[idx][WORD_W-1:0];
            RGN_TIME: rd_word = hi_word ? now_w[TIME_W-1:WORD_W] : now_w[WORD_W-1:0];
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (accept) bus_rdata <= bus_we ? '0 : rd_word;
    end
endmodule

// File: rtl/hart_timer_ipi_chk.sv
module hart_timer_ipi_chk
    import hart_timer_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             tick_en,
    input logic                             bus_req,
    input logic                             bus_we,
    input logic                             bus_ready,
    input logic [NUM_HARTS-1:0]             msip_o,
    input logic [NUM_HARTS-1:0]             mtip_o,
    input logic [TIME_W-1:0]                now,
    input logic [NUM_HARTS-1:0][TIME_W-1:0] cmp
);
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_ready_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    assert_ready_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && bus_ready |-> $past(bus_req));

    assert_msip_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$stable(msip_o) |-> $past(bus_req && bus_we));

    assert_time_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(tick_en) |-> now == $past(now) + TIME_W'(1));

    assert_time_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(tick_en) |-> now == $past(now));

    generate
        for (genvar h = 0; h < NUM_HARTS; h++) begin : g_mt
            assert_mtip_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
                armed_q |-> mtip_o[h] == ($past(cmp[h]) <= $past(now)));
        end
    endgenerate
endmodule

bind hart_timer_ipi hart_timer_ipi_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ready (bus_ready),
    .msip_o    (msip_o),
    .mtip_o    (mtip_o),
    .now       (now_w),
    .cmp       (cmp_w)
);

// File: tb/hart_timer_ipi_bench.sv
module hart_timer_ipi_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 2;
    localparam logic [15:0] SWI        = 16'h0000;
    localparam logic [15:0] CMP        = 16'h4000;
    localparam logic [15:0] TB         = 16'hBFF8;
    localparam logic [63:0] TIME_RST   = 64'h0000_0000_FFFF_FFF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ready;
    logic [N-1:0]  msip_o, mtip_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit running = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hart_timer_ipi #(
        .NUM_HARTS(N), .ADDR_W(16), .SWI_BASE(SWI), .CMP_BASE(CMP),
        .TIME_BASE(TB), .TIME_RESET(TIME_RST)
    ) u_hart_timer_ipi (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .msip_o(msip_o), .mtip_o(mtip_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [63:0] m_time;
    logic [63:0] m_cmp [N];
    logic [N-1:0] m_msip, m_mtip;
    logic        m_busy, m_isrd;
    logic [31:0] m_rd;
    logic [63:0] m_lo_time;
    string       m_tag;
    int          k, ix;
    bit          hh;

    function automatic void dec(input logic [15:0] a, output int kind, output int idx, output bit hi);
        int ra;
        ra = int'(a);
        kind = 0; idx = 0; hi = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (ra >= int'(SWI) && ra - int'(SWI) < 4*N) begin
                kind = 1; idx = (ra - int'(SWI)) / 4;
            end else if (ra >= int'(CMP) && ra - int'(CMP) < 8*N) begin
                kind = 2; idx = (ra - int'(CMP)) / 8; hi = ((ra - int'(CMP)) % 8) == 4;
            end else if (ra == int'(TB)) begin
                kind = 3;
            end else if (ra == int'(TB) + 4) begin
                kind = 3; hi = 1'b1;
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_time <= TIME_RST;
            for (int i = 0; i < N; i++) m_cmp[i] <= '0;
            m_msip <= '0; m_mtip <= '0; m_busy <= 1'b0; m_isrd <= 1'b0;
            m_rd <= '0; m_lo_time <= '0; m_tag <= "R1";
        end else begin
            if (tick_en) m_time <= m_time + 64'd1;
            for (int i = 0; i < N; i++) m_mtip[i] <= (m_cmp[i] <= m_time);
            m_busy <= !m_busy && bus_req;
            if (!m_busy && bus_req) begin
                dec(bus_addr, k, ix, hh);
                m_isrd <= !bus_we;
                if (bus_we) begin
                    if (k == 1) m_msip[ix] <= bus_wdata[0];
                    if (k == 2 && hh)  m_cmp[ix][63:32] <= bus_wdata;
                    if (k == 2 && !hh) m_cmp[ix][31:0]  <= bus_wdata;
                end else begin
                    case (k)
                        1: begin m_rd <= {31'b0, m_msip[ix]}; m_tag <= "R2 read"; end
                        2: begin m_rd <= hh ? m_cmp[ix][63:32] : m_cmp[ix][31:0]; m_tag <= "R3 read"; end
                        3: begin
                            m_rd <= hh ? m_time[63:32] : m_time[31:0]; m_tag <= "R7 read";
                            if (!hh) m_lo_time <= m_time;
                        end
                        default: begin m_rd <= '0; m_tag <= "R8 read"; end
                    endcase
                end
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk(bus_ready == m_busy, "R1 ready", 64'(bus_ready), 64'(m_busy));
            chk(msip_o == m_msip, "R2 msip", 64'(msip_o), 64'(m_msip));
            chk(mtip_o == m_mtip, "R5 mtip", 64'(mtip_o), 64'(m_mtip));
            if (bus_ready && m_isrd)
                chk(bus_rdata == m_rd, m_tag, 64'(bus_rdata), 64'(m_rd));
        end
    end

    task automatic xfer(input bit we, input logic [15:0] a, input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        rd = bus_rdata;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        logic [31:0] unused;
        xfer(1'b1, a, d, unused);
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] v);
        xfer(1'b0, a, 32'h0, v);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, h1, h2, lo;
        logic [63:0] t, composed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R9: reset values
        for (int h = 0; h < N; h++) begin
            rd(CMP + 16'(8*h), v);     chk(v == 0, "R9 cmp lo reset", 64'(v), 0);
            rd(CMP + 16'(8*h + 4), v); chk(v == 0, "R9 cmp hi reset", 64'(v), 0);
        end
        chk(msip_o == '0, "R9 msip reset", 64'(msip_o), 0);
        rd(TB, v); chk(v == TIME_RST[31:0], "R9 time reset", 64'(v), 64'(TIME_RST[31:0]));
        @(negedge clk);
        chk(bus_ready == 1'b0, "R1 single ready", 64'(bus_ready), 0);

        // R10: hi-lo-hi across low-word rollover
        tick_en = 1'b1;
        for (int it = 0; it < 8; it++) begin
            do begin
                rd(TB + 16'd4, h1); rd(TB, lo); t = m_lo_time; rd(TB + 16'd4, h2);
            end while (h1 != h2);
            composed = {h1, lo};
            chk(composed == t, "R10 hi-lo-hi value", composed, t);
        end
        chk(composed >= 64'h1_0000_0000, "R10 crossed rollover", composed, 64'h1_0000_0000);
        tick_en = 1'b0;

        // R6: exact tick count
        rd(TB, v);
        @(negedge clk); tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd(TB, h1);
        chk(h1 == v + 32'd5, "R6 five ticks", 64'(h1), 64'(v + 32'd5));

        // R3 / R4: compare layout and half writes
        wr(CMP + 16'd8, 32'hA5A5_0001); wr(CMP + 16'd12, 32'h0000_0002);
        rd(CMP + 16'd8, v);  chk(v == 32'hA5A5_0001, "R3 cmp1 lo", 64'(v), 64'hA5A5_0001);
        rd(CMP + 16'd12, v); chk(v == 32'h2, "R3 cmp1 hi", 64'(v), 2);
        wr(CMP + 16'd8, 32'h1111_2222);
        rd(CMP + 16'd12, v); chk(v == 32'h2, "R4 hi kept", 64'(v), 2);
        wr(CMP + 16'd12, 32'h3);
        rd(CMP + 16'd8, v);  chk(v == 32'h1111_2222, "R4 lo kept", 64'(v), 64'h1111_2222);

        // R5: equality, future, unsigned compare
        t = m_time;
        wr(CMP + 16'd4, t[63:32]); wr(CMP, t[31:0]);
        @(negedge clk);
        chk(mtip_o[0] == 1'b1, "R5 equal asserts", 64'(mtip_o[0]), 1);
        wr(CMP, t[31:0] + 32'd1);
        @(negedge clk);
        chk(mtip_o[0] == 1'b0, "R5 future deasserts", 64'(mtip_o[0]), 0);
        wr(CMP + 16'd4, 32'h8000_0000);
        @(negedge clk);
        chk(mtip_o[0] == 1'b0, "R5 unsigned", 64'(mtip_o[0]), 0);
        // compare write racing the running counter
        tick_en = 1'b1;
        wr(CMP, t[31:0] + 32'd5); wr(CMP + 16'd4, t[63:32]);
        repeat (10) @(negedge clk);
        chk(mtip_o[0] == 1'b1, "R5 crossing", 64'(mtip_o[0]), 1);
        tick_en = 1'b0;

        // R7: time writes ignored
        rd(TB, lo); rd(TB + 16'd4, h1);
        wr(TB, 32'hDEAD_0000); wr(TB + 16'd4, 32'hBEEF_0000);
        rd(TB, v);  chk(v == lo, "R7 lo unchanged", 64'(v), 64'(lo));
        rd(TB + 16'd4, v); chk(v == h1, "R7 hi unchanged", 64'(v), 64'(h1));

        // R2: software interrupts
        wr(SWI + 16'd4, 32'h1);
        @(negedge clk); chk(msip_o == 2'b10, "R2 set hart1", 64'(msip_o), 2);
        rd(SWI + 16'd4, v); chk(v == 32'h1, "R2 read hart1", 64'(v), 1);
        wr(SWI, 32'hFFFF_FFFF);
        @(negedge clk); chk(msip_o == 2'b11, "R2 set hart0", 64'(msip_o), 3);
        wr(SWI + 16'd4, 32'hFFFF_FFFE);
        @(negedge clk); chk(msip_o == 2'b01, "R2 clear by bit0", 64'(msip_o), 1);

        // R8: illegal accesses
        rd(SWI + 16'd1, v); chk(v == 0, "R8 misaligned read", 64'(v), 0);
        wr(SWI + 16'd5, 32'h1);
        @(negedge clk); chk(msip_o == 2'b01, "R8 misaligned write", 64'(msip_o), 1);
        wr(SWI + 16'd8, 32'h1);
        rd(SWI + 16'd8, v); chk(v == 0, "R8 hart out of range", 64'(v), 0);
        chk(msip_o == 2'b01, "R8 oor write", 64'(msip_o), 1);
        rd(CMP + 16'd16, v); chk(v == 0, "R8 cmp oor read", 64'(v), 0);
        wr(CMP + 16'd10, 32'hFFFF);
        rd(CMP + 16'd8, v); chk(v == 32'h1111_2222, "R8 cmp misaligned write", 64'(v), 64'h1111_2222);
        rd(16'h2000, v); chk(v == 0, "R8 unmapped read", 64'(v), 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule